// File: doc/BRIEF.md
# DDR Burst Column Address Sequencer

This block produces the column addresses of one DDR SDRAM read or write burst. A one-cycle start pulse carries a 9-bit start column, a burst-length code and an order bit. The block then walks the burst in wrapped-sequential or XOR-interleaved order. Two data beats move in every clock, so the block presents one address pair per clock: the even-numbered beat and the odd-numbered beat. A burst of BL beats therefore occupies BL/2 clocks.

A valid flag marks the address-pair cycles, and a last flag marks the final pair. If a new start arrives in the last cycle, the next burst follows with no idle clock. A stop input ends a read burst early. During a write burst, stop is ignored. A start that carries a reserved length code is dropped and raises a one-cycle error flag.

Top module: `ddr_burst_colseq`

## Requirements
- R1: While `rst_n` is low at a rising edge, `valid_o`, `last_o` and `err_o` are all 0 after that edge.
- R2: A start is accepted when `start_i` is high at a rising edge, the block is idle or in its last cycle, and the length code is valid. Code 1 gives BL=2, code 2 gives BL=4 and code 3 gives BL=8. After the accepting edge, `valid_o` is high for exactly BL/2 cycles and then falls, unless another start is accepted.
- R3: With `order_i`=0 (sequential), beat n has low bits (s+n) mod BL, where s is the low log2(BL) bits of the start column.
- R4: With `order_i`=1 (interleave), beat n has low bits s XOR n.
- R5: In pair cycle i (counted from 0), `addr_even_o` carries beat 2i and `addr_odd_o` carries beat 2i+1.
- R6: Column bits above the low log2(BL) bits equal those of the start column for the whole burst.
- R7: `last_o` is high only in the final pair cycle of a burst.
- R8: A valid start in the last cycle begins the new burst in the very next cycle, with no gap.
- R9: A start while a burst is running and not in its last cycle is ignored. The running burst continues unchanged.
- R10: With `stop_i` high at an edge during a read burst (`write_i`=0 at its start), `valid_o` is low after that edge.
- R11: `stop_i` has no effect during a write burst (`write_i`=1 at its start).
- R12: A start with length code 0 starts no burst. `err_o` is high for exactly the one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Burst start request |
| col_i | input | 9 | Start column |
| len_code_i | input | 2 | Burst-length code: 1, 2 or 3 selects BL 2, 4 or 8; 0 is reserved |
| order_i | input | 1 | 0 selects sequential order, 1 selects interleave |
| write_i | input | 1 | 1 marks the burst as a write |
| stop_i | input | 1 | Burst terminate request, honoured for reads only |
| addr_even_o | output | 9 | Column address of the even beat of the current pair |
| addr_odd_o | output | 9 | Column address of the odd beat of the current pair |
| valid_o | output | 1 | Address pair valid |
| last_o | output | 1 | Final pair of the burst |
| err_o | output | 1 | A start with a reserved length code was seen in the previous cycle |

## Verification
The hardest cases to reach are those where two requests land on the same burst cycle: a start in the final pair cycle versus a start in an earlier one, and a stop against a read versus against a write. The stimulus drives its inputs on falling edges and counts pair cycles from the accepting edge. It can therefore place a second start exactly on the `last_o` cycle, or one cycle earlier. It also places a stop on the second pair of a long read and of a long write. After each of these, it checks the following address pair to show whether the burst was replaced, continued or ended.

// File: rtl/colseq_pkg.sv
// Shared types for the burst column sequencer.
// Assumes: nothing beyond the standard language.
package colseq_pkg;
    typedef enum logic {
        ORD_WRAP = 1'b0,
        ORD_XOR  = 1'b1
    } order_e;
endpackage

// File: rtl/colseq_len_dec.sv
// Decodes a burst-length code into a low-bit mask and the final pair index.
// Assumes: code value c selects BL = 2**c; codes 1..MAX_LOG are legal.
module colseq_len_dec #(
    parameter int CODE_W  = 2,
    parameter int MAX_LOG = 3
) (
    input  logic [CODE_W-1:0]  code_i,
    output logic               ok_o,
    output logic [MAX_LOG-1:0] mask_o,
    output logic [MAX_LOG-2:0] last_pair_o
);
    // Legality and mask of the bits that move within the burst.
    always_comb begin
        ok_o = (int'(code_i) >= 1) && (int'(code_i) <= MAX_LOG);
        for (int b = 0; b < MAX_LOG; b++) begin
            mask_o[b] = (b < int'(code_i));
        end
        last_pair_o = mask_o[MAX_LOG-1:1];
    end
endmodule

// File: rtl/colseq_order.sv
// Computes the column of one beat from the base column, burst mask and order.
// Assumes: the pair index lies below BL/2, so the beat index stays inside the mask.
module colseq_order #(
    parameter int COL_W = 9,
    parameter int LOW_W = 3,
    parameter bit ODD   = 1'b0
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [LOW_W-1:0] mask_i,
    input  logic             xor_i,
    input  logic [LOW_W-2:0] pair_i,
    output logic [COL_W-1:0] addr_o
);
    logic [LOW_W-1:0] beat;
    logic [LOW_W-1:0] base_lo;
    logic [LOW_W-1:0] wrap_lo;
    logic [LOW_W-1:0] xor_lo;

    // Wrapped and XOR low bits; bits outside the mask keep the base value.
    always_comb begin
        beat    = {pair_i, ODD};
        base_lo = base_i[LOW_W-1:0];
        wrap_lo = ((base_lo + beat) & mask_i) | (base_lo & ~mask_i);
        xor_lo  = base_lo ^ (beat & mask_i);
        addr_o  = {base_i[COL_W-1:LOW_W], (xor_i ? xor_lo : wrap_lo)};
    end
endmodule

// File: rtl/ddr_burst_colseq.sv
// Burst column sequencer: one even/odd address pair per clock for a DDR burst.
// Assumes: synchronous active-low reset; stop is honoured for reads only;
// a start is taken only when idle or in the final pair cycle.
module ddr_burst_colseq
    import colseq_pkg::*;
#(
    parameter int COL_W   = 9,
    parameter int CODE_W  = 2,
    parameter int MAX_LOG = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [CODE_W-1:0] len_code_i,
    input  logic              order_i,
    input  logic              write_i,
    input  logic              stop_i,
    output logic [COL_W-1:0]  addr_even_o,
    output logic [COL_W-1:0]  addr_odd_o,
    output logic              valid_o,
    output logic              last_o,
    output logic              err_o
);
    localparam int PAIR_W = MAX_LOG - 1;

    logic               dec_ok;
    logic [MAX_LOG-1:0] dec_mask;
    logic [PAIR_W-1:0]  dec_lastp;

    logic               busy_q;
    logic               wr_q;
    order_e             ord_q;
    logic [COL_W-1:0]   base_q;
    logic [MAX_LOG-1:0] mask_q;
    logic [PAIR_W-1:0]  lastp_q;
    logic [PAIR_W-1:0]  idx_q;
    logic               err_q;

    logic               at_last;
    logic               accept;
    logic               stop_rd;
    logic [COL_W-1:0]   pair_addr [2];

    colseq_len_dec #(.CODE_W(CODE_W), .MAX_LOG(MAX_LOG)) u_dec (
        .code_i      (len_code_i),
        .ok_o        (dec_ok),
        .mask_o      (dec_mask),
        .last_pair_o (dec_lastp)
    );

    // One order unit per beat of the pair: even beat then odd beat.
    for (genvar g = 0; g < 2; g++) begin : g_beat
        colseq_order #(.COL_W(COL_W), .LOW_W(MAX_LOG), .ODD(g == 1)) u_ord (
            .base_i (base_q),
            .mask_i (mask_q),
            .xor_i  (ord_q == ORD_XOR),
            .pair_i (idx_q),
            .addr_o (pair_addr[g])
        );
    end

    // Acceptance and read-stop decisions for this cycle.
    always_comb begin
        at_last = busy_q && (idx_q == lastp_q);
        accept  = start_i && dec_ok && (!busy_q || at_last);
        stop_rd = busy_q && !wr_q && stop_i;
    end

    // Burst state: load on accept, step the pair index, end on last or read stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            wr_q    <= 1'b0;
            ord_q   <= ORD_WRAP;
            base_q  <= '0;
            mask_q  <= '0;
            lastp_q <= '0;
            idx_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= start_i && !dec_ok;
            if (accept) begin
                busy_q  <= 1'b1;
                wr_q    <= write_i;
                ord_q   <= order_e'(order_i);
                base_q  <= col_i;
                mask_q  <= dec_mask;
                lastp_q <= dec_lastp;
                idx_q   <= '0;
            end else if (at_last || stop_rd) begin
                busy_q <= 1'b0;
            end else if (busy_q) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Drive the ports from the burst state.
    always_comb begin
        addr_even_o = pair_addr[0];
        addr_odd_o  = pair_addr[1];
        valid_o     = busy_q;
        last_o      = at_last;
        err_o       = err_q;
    end

    // R7
    last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R8
    back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && start_i && len_code_i != '0) |=> valid_o);

    // R10
    read_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !wr_q && stop_i && !(start_i && last_o)) |=> !valid_o);

    // R11
    write_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && wr_q && !last_o) |=> valid_o);

    // R12
    reserved_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && len_code_i == '0) |=> err_o);

    // R6
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> $stable(addr_even_o[COL_W-1:MAX_LOG]));
endmodule

// File: tb/ddr_burst_colseq_tb.sv
module ddr_burst_colseq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [8:0] col_i = '0;
    logic [1:0] len_code_i = '0;
    logic       order_i = 1'b0;
    logic       write_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [8:0] addr_even_o, addr_odd_o;
    logic       valid_o, last_o, err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ddr_burst_colseq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
        .len_code_i(len_code_i), .order_i(order_i), .write_i(write_i),
        .stop_i(stop_i), .addr_even_o(addr_even_o), .addr_odd_o(addr_odd_o),
        .valid_o(valid_o), .last_o(last_o), .err_o(err_o)
    );

    // {start column, length code, order}
    localparam logic [11:0] VEC [10] = '{
        {9'h005, 2'd1, 1'b0}, {9'h005, 2'd1, 1'b1},
        {9'h00E, 2'd2, 1'b0}, {9'h00E, 2'd2, 1'b1},
        {9'h1F3, 2'd3, 1'b0}, {9'h1F3, 2'd3, 1'b1},
        {9'h12D, 2'd3, 1'b0}, {9'h12D, 2'd3, 1'b1},
        {9'h0A7, 2'd2, 1'b0}, {9'h100, 2'd3, 1'b1}
    };

    // Model of beat n from R3/R4.
    function automatic int beat_col(int col, int code, int xo, int n);
        int bl = 1 << code;
        int lo = col % bl;
        int hi = col - lo;
        if (xo != 0) return hi + (lo ^ n);
        return hi + ((lo + n) % bl);
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive a start for one edge; returns at the next falling edge.
    task automatic fire(int col, int code, int xo, int wr);
        start_i = 1'b1; col_i = 9'(col); len_code_i = 2'(code);
        order_i = xo[0]; write_i = wr[0];
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Check the pair shown in pair cycle p (R3/R4 even, R5 odd, R7 last).
    task automatic chk_pair(int col, int code, int xo, int p);
        int last_p = (1 << code) / 2 - 1;
        chk("R2 valid", int'(valid_o), 1);
        chk(xo != 0 ? "R4 even" : "R3 even", int'(addr_even_o), beat_col(col, code, xo, 2*p));
        chk("R5 odd", int'(addr_odd_o), beat_col(col, code, xo, 2*p+1));
        chk("R7 last", int'(last_o), (p == last_p) ? 1 : 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid", int'(valid_o), 0);
        chk("R1 last", int'(last_o), 0);
        chk("R1 err", int'(err_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: every length and order.
        foreach (VEC[i]) begin
            int col  = int'(VEC[i][11:3]);
            int code = int'(VEC[i][2:1]);
            int xo   = int'(VEC[i][0]);
            int bl   = 1 << code;
            fire(col, code, xo, 0);
            for (int p = 0; p < bl/2; p++) begin
                chk_pair(col, code, xo, p);
                chk("R6 upper", int'(addr_odd_o) / bl, col / bl);
                @(negedge clk);
            end
            chk("R2 end", int'(valid_o), 0);
        end

        // R8: back-to-back start on the last cycle.
        fire(9'h0E, 2, 0, 0);
        chk_pair(9'h0E, 2, 0, 0);
        @(negedge clk);
        chk("R8 last", int'(last_o), 1);
        fire(9'h1A, 3, 1, 0);
        chk_pair(9'h1A, 3, 1, 0);
        for (int p = 1; p < 4; p++) begin
            @(negedge clk);
            chk_pair(9'h1A, 3, 1, p);
        end
        @(negedge clk);
        chk("R8 end", int'(valid_o), 0);

        // R9: start mid-burst is ignored.
        fire(9'h041, 3, 0, 0);
        chk_pair(9'h041, 3, 0, 0);
        fire(9'h0F0, 1, 1, 0);
        chk_pair(9'h041, 3, 0, 1);
        chk("R9 addr", int'(addr_even_o), beat_col(9'h041, 3, 0, 2));
        @(negedge clk);
        chk_pair(9'h041, 3, 0, 2);
        @(negedge clk);
        chk_pair(9'h041, 3, 0, 3);
        @(negedge clk);
        chk("R9 end", int'(valid_o), 0);

        // R10: read stop ends the burst.
        fire(9'h033, 3, 0, 0);
        @(negedge clk);
        chk_pair(9'h033, 3, 0, 1);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R10 stop", int'(valid_o), 0);
        @(negedge clk);

        // R11: write stop ignored.
        fire(9'h033, 3, 1, 1);
        @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R11 valid", int'(valid_o), 1);
        chk_pair(9'h033, 3, 1, 2);
        @(negedge clk);
        chk_pair(9'h033, 3, 1, 3);
        @(negedge clk);

        // R12: reserved code ignored, one-cycle error.
        fire(9'h011, 0, 0, 0);
        chk("R12 no burst", int'(valid_o), 0);
        chk("R12 err", int'(err_o), 1);
        @(negedge clk);
        chk("R12 err clear", int'(err_o), 0);
        chk("R12 idle", int'(valid_o), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule